// File: doc/BRIEF.md
# Phase-Change Memory Bank Scheduler with Early Pre-Set

This block schedules requests for one bank of a phase-change memory. It accepts three kinds of request, each into its own queue: reads, writes, and address-only pre-set jobs. A pre-set job drives a line into the slow-to-program state ahead of time. It picks one operation at a time, sends it to the bank as a one-cycle command, and keeps the bank busy for that operation's service time with a down-counter. When the operation ends it reports completion on a one-cycle done pulse together with the address.

Writing the slow cell state takes far longer than writing the fast one. A write whose line has already been pre-set therefore needs only the fast transitions, and it is served with a short latency close to a read's. Any other write takes the long latency. Pre-set jobs take the long latency too. They have the lowest priority and give way to reads. An optional mode, chosen by a pin, lets a newly arriving read abort a long write that is in progress. The aborted write stays queued and is later done again from the start.

Top module: `pcm_bank_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_valid`, `rd_done`, `wr_done` and `ps_done` are all low and every queue is empty.
- R2: When the bank is idle, the grant goes in this order. A write comes first if the write queue is full. Otherwise a pending read goes first, then a pending write, then a pending pre-set job. Each pick takes the head of its queue.
- R3: The bank stays busy for RD_LAT cycles on a read, SHORT_WR_LAT on a write flagged as pre-set, LONG_WR_LAT on any other write, and PS_LAT on a pre-set job. The done pulse comes exactly that many cycles after the command pulse.
- R4: A command is a one-cycle `cmd_valid` pulse with `cmd_addr`. `cmd_op` is encoded as follows: 0 is read, 1 is short write, 2 is long write, 3 is pre-set. The pulse comes one cycle after the idle cycle in which the grant was made.
- R5: A pre-set job in progress is abandoned at the first clock edge at which the read queue holds an entry. The job stays at the head of its queue and later restarts with its full latency. Only the finished run produces `ps_done`.
- R6: When `cancel_en` is 1, a read accepted while a long write is in progress aborts that write, unless the write queue is full. The write stays queued and is issued again later with its full latency. Short writes are never aborted.
- R7: When `cancel_en` is 0, every write runs to completion, even if reads arrive while it is in progress.
- R8: Completion is shown by a one-cycle pulse on exactly one of `rd_done`, `wr_done` or `ps_done`, with the operation's address on `done_addr`. No done pulse ever coincides with `cmd_valid`.
- R9: A request offered to a full queue is dropped and never produces a command.
- R10: Within each queue, requests are served in arrival order, and an entry leaves its queue only when its operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cancel_en | input | 1 | Allows arriving reads to abort long writes |
| rd_valid | input | 1 | Enqueue a read |
| rd_addr | input | ADDR_W | Read line address |
| wr_valid | input | 1 | Enqueue a write |
| wr_addr | input | ADDR_W | Write line address |
| wr_preset | input | 1 | The write's line was pre-set (short write) |
| ps_valid | input | 1 | Enqueue a pre-set job |
| ps_addr | input | ADDR_W | Pre-set line address |
| cmd_valid | output | 1 | Bank command pulse |
| cmd_op | output | 2 | Command kind (0 read, 1 short write, 2 long write, 3 pre-set) |
| cmd_addr | output | ADDR_W | Command address |
| rd_done | output | 1 | Read completion pulse |
| wr_done | output | 1 | Write completion pulse |
| ps_done | output | 1 | Pre-set completion pulse |
| done_addr | output | ADDR_W | Address of the completed operation |

## Verification
The hardest case to reach from the ports is the forced write. It needs the write queue to be full at the very moment the bank goes idle while a read is also waiting. This works only because entries leave a queue at completion, not at issue. The stimulus therefore starts a read and, during its short busy time, fills the write queue one entry per cycle and queues a second read. The write must then win the next grant. Aborts are produced by sending a read a few cycles into a pre-set job and into a long write, once with cancellation off and once with it on. A long random phase follows, checked cycle by cycle against a behavioural queue model.

// File: rtl/pcm_sched_pkg.sv
// Shared types for the bank scheduler.
// Assumes: the operation encoding below is also the cmd_op port encoding.
package pcm_sched_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WRS = 2'd1,
        OP_WRL = 2'd2,
        OP_PS  = 2'd3
    } bank_op_e;
endpackage

// File: rtl/pcm_req_fifo.sv
// Request FIFO: stores DEPTH entries of W bits, drops a push into a full queue,
// and shows the head entry combinationally.
// Assumes: the owner pops only when it has finished with the head entry.
module pcm_req_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status and gated handshakes.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = mem[rd_ptr];
    end

    // Entry storage (no reset needed: guarded by count).
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> full && $stable(wr_ptr));
    // R10
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/pcm_grant.sv
// Grant selection for an idle bank: forced write on a full write queue, then
// read, write, pre-set. Chooses the short or long write kind from the head flag.
// Assumes: inputs reflect registered queue state only.
module pcm_grant
    import pcm_sched_pkg::*;
(
    input  logic     rd_any,
    input  logic     wr_any,
    input  logic     wr_full,
    input  logic     ps_any,
    input  logic     wr_head_pre,
    output logic     gnt,
    output bank_op_e gnt_op
);
    // Fixed-priority pick.
    always_comb begin
        gnt    = 1'b1;
        gnt_op = OP_RD;
        if (wr_full || (!rd_any && wr_any)) gnt_op = wr_head_pre ? OP_WRS : OP_WRL;
        else if (rd_any)                    gnt_op = OP_RD;
        else if (ps_any)                    gnt_op = OP_PS;
        else                                gnt    = 1'b0;
    end
endmodule

// File: rtl/pcm_bank_sched.sv
// Per-bank scheduler for a phase-change memory bank. Holds read, write and
// pre-set queues, issues one operation at a time and times the bank with a
// down-counter. Pre-set jobs yield to pending reads; long writes optionally
// yield to arriving reads. Queue entries retire only on completion.
// Assumes: cancel_en is a quasi-static mode pin; latencies are all >= 1.
module pcm_bank_sched
    import pcm_sched_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int RD_DEPTH     = 8,
    parameter int WR_DEPTH     = 32,
    parameter int PS_DEPTH     = 8,
    parameter int RD_LAT       = 500,
    parameter int SHORT_WR_LAT = 600,
    parameter int LONG_WR_LAT  = 4000,
    parameter int PS_LAT       = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cancel_en,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_preset,
    input  logic              ps_valid,
    input  logic [ADDR_W-1:0] ps_addr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rd_done,
    output logic              wr_done,
    output logic              ps_done,
    output logic [ADDR_W-1:0] done_addr
);
    localparam int MAX_A = (RD_LAT > SHORT_WR_LAT) ? RD_LAT : SHORT_WR_LAT;
    localparam int MAX_B = (LONG_WR_LAT > PS_LAT) ? LONG_WR_LAT : PS_LAT;
    localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_L + 1);

    logic [ADDR_W-1:0] rd_head, ps_head, iss_addr, cur_addr;
    logic [ADDR_W:0]   wr_head;
    logic              rd_full, rd_empty, wr_full, wr_empty, ps_full, ps_empty;
    logic              rd_pop, wr_pop, ps_pop;
    logic              busy, finish, abort, rd_arrive, gnt;
    bank_op_e          cur_op, gnt_op;
    logic [CNT_W-1:0]  cnt;

    function automatic logic [CNT_W-1:0] lat_of(input bank_op_e op);
        case (op)
            OP_RD:   return CNT_W'(RD_LAT);
            OP_WRS:  return CNT_W'(SHORT_WR_LAT);
            OP_WRL:  return CNT_W'(LONG_WR_LAT);
            default: return CNT_W'(PS_LAT);
        endcase
    endfunction

    pcm_req_fifo #(.W(ADDR_W), .DEPTH(RD_DEPTH)) i_rd_q (
        .clk(clk), .rst_n(rst_n), .push(rd_valid), .push_data(rd_addr),
        .pop(rd_pop), .head(rd_head), .full(rd_full), .empty(rd_empty));

    pcm_req_fifo #(.W(ADDR_W + 1), .DEPTH(WR_DEPTH)) i_wr_q (
        .clk(clk), .rst_n(rst_n), .push(wr_valid), .push_data({wr_preset, wr_addr}),
        .pop(wr_pop), .head(wr_head), .full(wr_full), .empty(wr_empty));

    pcm_req_fifo #(.W(ADDR_W), .DEPTH(PS_DEPTH)) i_ps_q (
        .clk(clk), .rst_n(rst_n), .push(ps_valid), .push_data(ps_addr),
        .pop(ps_pop), .head(ps_head), .full(ps_full), .empty(ps_empty));

    pcm_grant i_grant (
        .rd_any(!rd_empty), .wr_any(!wr_empty), .wr_full(wr_full), .ps_any(!ps_empty),
        .wr_head_pre(wr_head[ADDR_W]), .gnt(gnt), .gnt_op(gnt_op));

    // Completion, abort and retirement decisions for the running operation.
    always_comb begin
        rd_arrive = rd_valid && !rd_full;
        finish    = busy && (cnt == CNT_W'(1));
        abort     = busy && !finish &&
                    ((cur_op == OP_PS && !rd_empty) ||
                     (cancel_en && cur_op == OP_WRL && rd_arrive && !wr_full));
        rd_pop    = finish && (cur_op == OP_RD);
        wr_pop    = finish && (cur_op == OP_WRS || cur_op == OP_WRL);
        ps_pop    = finish && (cur_op == OP_PS);
        case (gnt_op)
            OP_RD:   iss_addr = rd_head;
            OP_PS:   iss_addr = ps_head;
            default: iss_addr = wr_head[ADDR_W-1:0];
        endcase
    end

    // Bank occupancy, command and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            cur_op    <= OP_RD;
            cur_addr  <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= 2'd0;
            cmd_addr  <= '0;
            rd_done   <= 1'b0;
            wr_done   <= 1'b0;
            ps_done   <= 1'b0;
            done_addr <= '0;
        end else begin
            cmd_valid <= 1'b0;
            rd_done   <= 1'b0;
            wr_done   <= 1'b0;
            ps_done   <= 1'b0;
            if (busy) begin
                if (finish) begin
                    busy      <= 1'b0;
                    cnt       <= '0;
                    rd_done   <= (cur_op == OP_RD);
                    wr_done   <= (cur_op == OP_WRS || cur_op == OP_WRL);
                    ps_done   <= (cur_op == OP_PS);
                    done_addr <= cur_addr;
                end else if (abort) begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (gnt) begin
                busy      <= 1'b1;
                cnt       <= lat_of(gnt_op);
                cur_op    <= gnt_op;
                cur_addr  <= iss_addr;
                cmd_valid <= 1'b1;
                cmd_op    <= gnt_op;
                cmd_addr  <= iss_addr;
            end
        end
    end

    // R3
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cnt != '0);
    // R4
    cmd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);
    // R8
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rd_done, wr_done, ps_done}));
    // R8
    ps_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_done |=> !ps_done);
    // R5
    ps_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_op == OP_PS && !rd_empty && cnt != CNT_W'(1) |=> !busy);
    // R7
    no_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cur_op == OP_WRL && !cancel_en && cnt != CNT_W'(1) |=> busy);
    // R9
    ps_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_full && !ps_pop |=> ps_full);
endmodule

// File: tb/test_pcm_bank_sched.sv
module test_pcm_bank_sched;
    localparam int AW = 8, RDD = 4, WRD = 4, PSD = 4;
    localparam int RL = 8, SL = 10, LL = 40, PL = 40;

    logic clk = 1'b0, rst_n = 1'b0, cancel_en = 1'b0;
    logic rd_valid = 0, wr_valid = 0, wr_preset = 0, ps_valid = 0;
    logic [AW-1:0] rd_addr = 0, wr_addr = 0, ps_addr = 0;
    logic cmd_valid, rd_done, wr_done, ps_done;
    logic [1:0] cmd_op;
    logic [AW-1:0] cmd_addr, done_addr;

    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    pcm_bank_sched #(.ADDR_W(AW), .RD_DEPTH(RDD), .WR_DEPTH(WRD), .PS_DEPTH(PSD),
        .RD_LAT(RL), .SHORT_WR_LAT(SL), .LONG_WR_LAT(LL), .PS_LAT(PL)) i_pcm_bank_sched (
        .clk(clk), .rst_n(rst_n), .cancel_en(cancel_en),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_preset(wr_preset),
        .ps_valid(ps_valid), .ps_addr(ps_addr),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .rd_done(rd_done), .wr_done(wr_done), .ps_done(ps_done), .done_addr(done_addr));

    // ---------------- behavioural reference model ----------------
    int rq[$], wq[$], pq[$];
    bit wp[$];
    bit started = 0, mbusy = 0, m_cmd_v = 0, m_rdd = 0, m_wrd = 0, m_psd = 0;
    bit rpush, wpush, ppush, wfull;
    int mop = 0, maddr = 0, mcnt = 0, m_op = 0, m_addr = 0, m_daddr = 0, sel;

    function automatic int lat(input int s);
        case (s)
            0: return RL;
            1: return SL;
            2: return LL;
            default: return PL;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1;
        m_cmd_v = 0; m_rdd = 0; m_wrd = 0; m_psd = 0;
        if (!rst_n) begin
            rq.delete(); wq.delete(); wp.delete(); pq.delete();
            mbusy = 0; mcnt = 0;
        end else begin
            rpush = rd_valid && rq.size() < RDD;
            wpush = wr_valid && wq.size() < WRD;
            ppush = ps_valid && pq.size() < PSD;
            wfull = wq.size() == WRD;
            if (mbusy) begin
                if (mcnt == 1) begin
                    mbusy = 0;
                    m_daddr = maddr;
                    if (mop == 0) begin m_rdd = 1; void'(rq.pop_front()); end
                    else if (mop == 3) begin m_psd = 1; void'(pq.pop_front()); end
                    else begin m_wrd = 1; void'(wq.pop_front()); void'(wp.pop_front()); end
                end else if ((mop == 3 && rq.size() > 0) ||
                             (cancel_en && mop == 2 && rpush && !wfull)) begin
                    mbusy = 0;
                end else begin
                    mcnt = mcnt - 1;
                end
            end else begin
                sel = -1;
                if (wfull) sel = wp[0] ? 1 : 2;
                else if (rq.size() > 0) sel = 0;
                else if (wq.size() > 0) sel = wp[0] ? 1 : 2;
                else if (pq.size() > 0) sel = 3;
                if (sel >= 0) begin
                    mop = sel;
                    maddr = (sel == 0) ? rq[0] : ((sel == 3) ? pq[0] : wq[0]);
                    mcnt = lat(sel);
                    mbusy = 1;
                    m_cmd_v = 1; m_op = sel; m_addr = maddr;
                end
            end
            if (rpush) rq.push_back(int'(rd_addr));
            if (wpush) begin wq.push_back(int'(wr_addr)); wp.push_back(wr_preset); end
            if (ppush) pq.push_back(int'(ps_addr));
        end
    end

    // Cycle-by-cycle comparison (R4 commands, R8 completions).
    always @(negedge clk) if (started) begin
        checks++;
        if (cmd_valid !== m_cmd_v ||
            (m_cmd_v && (int'(cmd_op) != m_op || int'(cmd_addr) != m_addr))) begin
            errors++;
            $display("FAIL R4 cmd v/op/addr actual %b/%0d/%0h expected %b/%0d/%0h",
                     cmd_valid, cmd_op, cmd_addr, m_cmd_v, m_op, m_addr);
        end
        checks++;
        if ({rd_done, wr_done, ps_done} !== {m_rdd, m_wrd, m_psd} ||
            ((m_rdd || m_wrd || m_psd) && int'(done_addr) != m_daddr)) begin
            errors++;
            $display("FAIL R8 done r/w/p/addr actual %b%b%b/%0h expected %b%b%b/%0h",
                     rd_done, wr_done, ps_done, done_addr, m_rdd, m_wrd, m_psd, m_daddr);
        end
    end

    // ---------------- event monitor ----------------
    int cyc_n = 0, t_cmd = 0, span = 0, t_rdd = 0, t_wrd = 0;
    int n_cmd[4] = '{0, 0, 0, 0};
    int n_rdd = 0, n_wrd = 0, n_psd = 0, last_ps_addr = 0;
    int rd_log[$];
    bit capture = 0;
    int cap_op = -1, cap_addr = -1;

    always @(negedge clk) begin
        cyc_n++;
        if (cmd_valid === 1'b1) begin
            n_cmd[cmd_op]++;
            t_cmd = cyc_n;
            if (capture) begin cap_op = int'(cmd_op); cap_addr = int'(cmd_addr); capture = 0; end
        end
        if (rd_done === 1'b1) begin n_rdd++; t_rdd = cyc_n; rd_log.push_back(int'(done_addr)); end
        if (wr_done === 1'b1) begin n_wrd++; t_wrd = cyc_n; span = cyc_n - t_cmd; end
        if (ps_done === 1'b1) begin n_psd++; last_ps_addr = int'(done_addr); span = cyc_n - t_cmd; end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic rv, input int ra, input logic wv, input int wa,
                       input logic wpre, input logic pv, input int pa);
        rd_valid = rv; rd_addr = AW'(ra);
        wr_valid = wv; wr_addr = AW'(wa); wr_preset = wpre;
        ps_valid = pv; ps_addr = AW'(pa);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        rd_valid = 0; wr_valid = 0; ps_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: an expired run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int b0, b1, b2, b3;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 cmd_valid in reset", int'(cmd_valid), 0);
        chk("R1 done pulses in reset", int'({rd_done, wr_done, ps_done}), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 cmd_valid after reset", int'(cmd_valid), 0);

        // R3: short write latency, then long write latency
        cyc(0, 0, 1, 8'h21, 1, 0, 0); idle(30);
        chk("R3 short write span", span, SL);
        chk("R4 short write op count", n_cmd[1], 1);
        cyc(0, 0, 1, 8'h22, 0, 0, 0); idle(60);
        chk("R3 long write span", span, LL);

        // R7: cancellation off, read waits behind long write
        cancel_en = 0;
        b0 = n_cmd[2]; b1 = n_wrd;
        cyc(0, 0, 1, 8'h10, 0, 0, 0); idle(5);
        cyc(1, 8'h11, 0, 0, 0, 0, 0); idle(80);
        chk("R7 long write issued once", n_cmd[2] - b0, 1);
        chk("R7 write done before read", int'(t_rdd > t_wrd), 1);

        // R6: cancellation on, read aborts long write, write redone
        cancel_en = 1;
        b0 = n_cmd[2]; b1 = n_wrd;
        cyc(0, 0, 1, 8'h12, 0, 0, 0); idle(5);
        cyc(1, 8'h13, 0, 0, 0, 0, 0); idle(90);
        chk("R6 long write issued twice", n_cmd[2] - b0, 2);
        chk("R6 one write completion", n_wrd - b1, 1);
        chk("R6 read done before write", int'(t_rdd < t_wrd), 1);
        // R6: short writes are never aborted
        b0 = n_cmd[1];
        cyc(0, 0, 1, 8'h14, 1, 0, 0); idle(3);
        cyc(1, 8'h15, 0, 0, 0, 0, 0); idle(40);
        chk("R6 short write not reissued", n_cmd[1] - b0, 1);
        chk("R6 short write done first", int'(t_wrd < t_rdd), 1);

        // R5: pre-set yields to a read and restarts
        b0 = n_cmd[3]; b1 = n_psd;
        cyc(0, 0, 0, 0, 0, 1, 8'h30); idle(5);
        cyc(1, 8'h31, 0, 0, 0, 0, 0); idle(100);
        chk("R5 pre-set issued twice", n_cmd[3] - b0, 2);
        chk("R5 one pre-set completion", n_psd - b1, 1);
        chk("R5 pre-set done address", last_ps_addr, 8'h30);
        chk("R3 restarted pre-set full span", span, PL);

        // R2: full write queue forces a write ahead of a waiting read
        cancel_en = 0;
        cyc(1, 8'h40, 0, 0, 0, 0, 0);
        cyc(1, 8'h41, 1, 8'h50, 1, 0, 0);
        cyc(0, 0, 1, 8'h51, 1, 0, 0);
        cyc(0, 0, 1, 8'h52, 1, 0, 0);
        cyc(0, 0, 1, 8'h53, 1, 0, 0);
        capture = 1;
        idle(120);
        chk("R2 forced write op", cap_op, 1);
        chk("R2 forced write addr", cap_addr, 8'h50);

        // R9: pushes into a full pre-set queue are dropped
        b0 = n_psd;
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 0, 1, 8'h70 + i);
        idle(300);
        chk("R9 pre-set completions", n_psd - b0, PSD);

        // R10: reads complete in arrival order
        rd_log.delete();
        cyc(1, 8'h60, 0, 0, 0, 0, 0);
        cyc(1, 8'h61, 0, 0, 0, 0, 0);
        cyc(1, 8'h62, 0, 0, 0, 0, 0);
        idle(60);
        chk("R10 read count", rd_log.size(), 3);
        if (rd_log.size() == 3) begin
            chk("R10 first read", rd_log[0], 8'h60);
            chk("R10 second read", rd_log[1], 8'h61);
            chk("R10 third read", rd_log[2], 8'h62);
        end

        // Random traffic, compared every cycle against the model
        b2 = n_rdd; b3 = n_wrd;
        for (int i = 0; i < 6000; i++) begin
            if (i == 3000) cancel_en = ~cancel_en;
            cyc(($urandom % 14) == 0, int'($urandom % 256),
                ($urandom % 10) == 0, int'($urandom % 256), 1'($urandom % 2),
                ($urandom % 9) == 0, int'($urandom % 256));
        end
        idle(800);
        chk("R8 random traffic made progress", int'((n_rdd - b2) > 0 && (n_wrd - b3) > 0), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule